// File: doc/BRIEF.md
# Serial Character Transmitter with Freeze

This block serializes characters for an asynchronous or isochronous serial line. Characters enter through a single-cycle write port that carries a data byte and an address flag. They queue in a four-entry FIFO and leave one frame at a time on `txd_o`. A frame is a low start bit, the data bits LSB first, an optional address/data marker bit, and one high stop bit. The line rests high between frames.

Bit timing comes from an external enable `bit_en_i`. In synchronous mode every enabled cycle shifts one bit. In oversampled mode a bit lasts 8, 16 or 32 enabled cycles. `rts_o` is high for as long as a frame occupies the line, so a local receiver can use it to ignore its own traffic.

The freeze input pauses the character stream without losing anything. When freeze is first seen, the characters already in the FIFO at that moment are still sent, together with any frame already on the line. After that the line holds idle and later writes wait in the FIFO. Dropping freeze lets the next waiting character go out. Freeze never cuts a frame short, because it only decides whether a new frame may start at a character boundary.

Top module: `uart_frz_tx`

## Requirements
- R1: After reset, `txd_o` is 1, `rts_o` is 0, `fifo_empty_o` is 1, `fifo_full_o` is 0, `fifo_level_o` is 0 and `overflow_o` is 0.
- R2: A frame is a 0 start bit, then N data bits LSB first, then a 1 stop bit. N = 5, 6, 7, 8 for `char_len_i` = 00, 01, 10, 11. Written bits at or above position N are never sent.
- R3: When `md_en_i` is 1, the value of `wr_addr_i` captured with the character is sent as one extra bit between the last data bit and the stop bit. When `md_en_i` is 0, no such bit is sent.
- R4: When `sync_i` is 1, each bit lasts one enabled cycle. When `sync_i` is 0, each bit lasts 8 enabled cycles for `ovs_sel_i`=00, 16 for 01, and 32 for 10 or 11.
- R5: While a frame is on the line, `txd_o` changes only after a cycle in which `bit_en_i` was 1.
- R6: The FIFO holds 4 characters and sends them in write order. `fifo_level_o` gives the count, `fifo_full_o` means 4, and `fifo_empty_o` means 0.
- R7: A write presented while `fifo_full_o` is 1 is discarded, and `overflow_o` is 1 in the following cycle only.
- R8: In the first cycle `freeze_i` is seen high, the characters already held in the FIFO, excluding that cycle's write, are still sent. After them, and after any frame already on the line, no new frame starts while `freeze_i` stays high.
- R9: When `freeze_i` falls, transmission continues with the oldest unsent character, and no character is lost or repeated.
- R10: `rts_o` is 1 exactly while a frame is on the line. `txd_o` is 1 whenever `rts_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write strobe, one character per cycle |
| wr_data_i | input | 8 | Character data |
| wr_addr_i | input | 1 | Address/data marker for multidrop frames |
| bit_en_i | input | 1 | Bit-clock enable |
| char_len_i | input | 2 | Data bits per character (5 to 8) |
| md_en_i | input | 1 | Append marker bit to each frame |
| sync_i | input | 1 | One bit per enabled cycle |
| ovs_sel_i | input | 2 | Oversampling select: 8, 16 or 32 |
| freeze_i | input | 1 | Pause after the FIFO drains |
| txd_o | output | 1 | Serial line, idles high |
| rts_o | output | 1 | Frame in progress |
| fifo_full_o | output | 1 | FIFO holds 4 characters |
| fifo_empty_o | output | 1 | FIFO holds no characters |
| fifo_level_o | output | 3 | FIFO occupancy |
| overflow_o | output | 1 | One-cycle pulse after a dropped write |

## Verification
The bench builds the block with its defaults: DEPTH of 4, 8-bit characters and a 32-cycle maximum divider. The shallow FIFO lets a few writes under freeze reach full, overflow and a held queue. The 32-cycle divider keeps the slowest bit period short enough to send several random characters at every oversampling setting. Freeze is applied both with the FIFO loaded and in the middle of a lone frame. A line monitor decodes every frame and compares it against a queue of accepted writes.

// File: rtl/uart_frz_tx_pkg.sv
package uart_frz_tx_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              addr;
    logic [CHAR_W-1:0] data;
  } tx_char_t;
endpackage

// File: rtl/uart_frz_fifo.sv
module uart_frz_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 9,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign dout_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wptr_q] <= din_i;
        wptr_q        <= nxt(wptr_q);
      end
      if (pop_i) rptr_q <= nxt(rptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + LW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - LW'(1);
    end
  end
endmodule

// File: rtl/uart_frz_baud.sv
module uart_frz_baud #(
  parameter int MAX_DIV = 32,
  localparam int CW     = $clog2(MAX_DIV)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       run_i,
  input  logic       sync_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [CW-1:0] cnt_q, lim;

  always_comb begin
    unique case (sel_i)
      2'b00:   lim = CW'(MAX_DIV / 4 - 1);
      2'b01:   lim = CW'(MAX_DIV / 2 - 1);
      default: lim = CW'(MAX_DIV - 1);
    endcase
  end

  assign tick_o = run_i && en_i && (sync_i || cnt_q == lim);

  // counter held at zero when idle so the start bit gets a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else if (en_i && !sync_i)    cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/uart_frz_shift.sv
module uart_frz_shift
  import uart_frz_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  tx_char_t   char_i,
  input  logic [1:0] len_i,
  input  logic       md_i,
  output logic       busy_o,
  output logic       last_o,
  output logic       txd_o
);
  localparam int FW = CHAR_W + 3;
  localparam int BW = $clog2(FW + 1);

  logic [FW-1:0] sreg_q, frame_d;
  logic [BW-1:0] bit_q, nb_q, nb_d, nd;
  logic          busy_q;

  assign nd   = BW'(5) + BW'(len_i);
  assign nb_d = nd + BW'(2) + BW'(md_i);

  always_comb begin
    frame_d    = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < CHAR_W; i++)
      if (BW'(i) < nd) frame_d[1+i] = char_i.data[i];
    if (md_i) frame_d[nd + BW'(1)] = char_i.addr;
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && tick_i && (bit_q == nb_q - BW'(1));
  assign txd_o  = busy_q ? sreg_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '1;
      bit_q  <= '0;
      nb_q   <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      sreg_q <= frame_d;
      bit_q  <= '0;
      nb_q   <= nb_d;
      busy_q <= 1'b1;
    end else if (last_o) begin
      busy_q <= 1'b0;
      sreg_q <= '1;
    end else if (busy_q && tick_i) begin
      sreg_q <= {1'b1, sreg_q[FW-1:1]};
      bit_q  <= bit_q + BW'(1);
    end
  end
endmodule

// File: rtl/uart_frz_tx.sv
module uart_frz_tx
  import uart_frz_tx_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int MAX_DIV = 32,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [CHAR_W-1:0] wr_data_i,
  input  logic              wr_addr_i,
  input  logic              bit_en_i,
  input  logic [1:0]        char_len_i,
  input  logic              md_en_i,
  input  logic              sync_i,
  input  logic [1:0]        ovs_sel_i,
  input  logic              freeze_i,
  output logic              txd_o,
  output logic              rts_o,
  output logic              fifo_full_o,
  output logic              fifo_empty_o,
  output logic [LW-1:0]     fifo_level_o,
  output logic              overflow_o
);
  tx_char_t      wr_char, head;
  logic          push, start, busy, last, tick;
  logic          frz_q, frz_first, permit, ovf_q;
  logic [LW-1:0] allow_q;

  assign wr_char = '{addr: wr_addr_i, data: wr_data_i};
  assign push    = wr_valid_i && !fifo_full_o;

  uart_frz_fifo #(.DEPTH(DEPTH), .W($bits(tx_char_t))) u_fifo (
    .clk_i, .rst_ni,
    .push_i (push),
    .din_i  (wr_char),
    .pop_i  (start),
    .dout_o (head),
    .level_o(fifo_level_o),
    .full_o (fifo_full_o),
    .empty_o(fifo_empty_o)
  );

  uart_frz_baud #(.MAX_DIV(MAX_DIV)) u_baud (
    .clk_i, .rst_ni,
    .en_i  (bit_en_i),
    .run_i (busy),
    .sync_i(sync_i),
    .sel_i (ovs_sel_i),
    .tick_o(tick)
  );

  uart_frz_shift u_shift (
    .clk_i, .rst_ni,
    .tick_i (tick),
    .start_i(start),
    .char_i (head),
    .len_i  (char_len_i),
    .md_i   (md_en_i),
    .busy_o (busy),
    .last_o (last),
    .txd_o  (txd_o)
  );

  // freeze: snapshot FIFO occupancy at first sight, drain only that many
  assign frz_first = freeze_i && !frz_q;
  assign permit    = !fifo_empty_o && (!freeze_i || frz_first || allow_q != '0);
  assign start     = permit && (!busy || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q   <= 1'b0;
      allow_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      frz_q <= freeze_i;
      ovf_q <= wr_valid_i && fifo_full_o;
      if (frz_first)             allow_q <= fifo_level_o - LW'(start);
      else if (freeze_i && start) allow_q <= allow_q - LW'(1);
    end
  end

  assign rts_o      = busy;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/uart_frz_tx_chk.sv
module uart_frz_tx_chk #(
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic          bit_en_i,
  input logic          txd_o,
  input logic          rts_o,
  input logic          fifo_full_o,
  input logic          fifo_empty_o,
  input logic [LW-1:0] fifo_level_o,
  input logic          overflow_o
);
  assert_idle_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_o |-> txd_o);

  assert_level_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level_o <= LW'(DEPTH));

  assert_flags_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_full_o && fifo_empty_o));

  assert_start_from_fifo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rts_o) |-> $past(!fifo_empty_o));

  assert_hold_without_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_o && $past(rts_o) && !$past(bit_en_i)) |-> $stable(txd_o));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> ($past(wr_valid_i) && $past(fifo_full_o)));

  assert_level_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fifo_full_o) |-> fifo_level_o >= LW'(DEPTH - 1));
endmodule

bind uart_frz_tx uart_frz_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .bit_en_i    (bit_en_i),
  .txd_o       (txd_o),
  .rts_o       (rts_o),
  .fifo_full_o (fifo_full_o),
  .fifo_empty_o(fifo_empty_o),
  .fifo_level_o(fifo_level_o),
  .overflow_o  (overflow_o)
);

// File: tb/uart_frz_tx_bench.sv
`timescale 1ns/1ps
module uart_frz_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_addr = 1'b0;
  logic       bit_en = 1'b1;
  logic [1:0] len = 2'b11;
  logic       md = 1'b0;
  logic       sync = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       freeze = 1'b0;
  logic       txd, rts, full, empty, ovf;
  logic [2:0] level;

  int  n_chk = 0, n_bad = 0;
  bit  mon_en = 1'b1;
  bit  done = 1'b0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  uart_frz_tx u_uart_frz_tx (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_addr_i(wr_addr), .bit_en_i(bit_en), .char_len_i(len), .md_en_i(md),
    .sync_i(sync), .ovs_sel_i(sel), .freeze_i(freeze), .txd_o(txd), .rts_o(rts),
    .fifo_full_o(full), .fifo_empty_o(empty), .fifo_level_o(level), .overflow_o(ovf)
  );

  function automatic int period(input logic s, input logic [1:0] q);
    if (s) return 1;
    return (q == 2'b00) ? 8 : (q == 2'b01) ? 16 : 32;
  endfunction

  function automatic logic [7:0] mask(input logic [7:0] d, input logic [1:0] l);
    return d & 8'((1 << (int'(l) + 5)) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // line monitor: decode each frame at bit centres
  task automatic rx_frame();
    int p = period(sync, sel);
    int nd = int'(len) + 5;
    logic [7:0] d = '0;
    logic a = 1'b0, stp;
    bit rts_ok = (rts === 1'b1);
    logic [8:0] e;
    repeat (p + p / 2) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      d[i] = txd;
      rts_ok &= (rts === 1'b1);
      repeat (p) @(negedge clk);
    end
    if (md) begin
      a = txd;
      repeat (p) @(negedge clk);
    end
    stp = txd;
    rts_ok &= (rts === 1'b1);
    chk(stp === 1'b1, "R2", "stop bit", int'(stp), 1);
    chk(rts_ok, "R10", "rts during frame", int'(rts_ok), 1);
    if (exp_q.size() == 0) begin
      chk(1'b0, "R8", "unexpected frame", int'(d), -1);
    end else begin
      e = exp_q.pop_front();
      chk(d === mask(e[7:0], len), "R2", "data bits", int'(d), int'(mask(e[7:0], len)));
      if (md) chk(a === e[8], "R3", "marker bit", int'(a), int'(e[8]));
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (mon_en && rst_n && txd === 1'b0) rx_frame();
  end

  task automatic put(input logic [7:0] d, input logic a);
    wr_valid = 1'b1; wr_data = d; wr_addr = a;
    if (!full) exp_q.push_back({a, d});
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (!(empty && !rts) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic run_cfg(input logic s, input logic [1:0] q, input logic [1:0] l,
                         input logic m, input int n);
    sync = s; sel = q; len = l; md = m;
    for (int i = 0; i < n; i++) begin
      repeat ($urandom % 3) @(negedge clk);
      while (full) @(negedge clk);
      put(8'($urandom), 1'($urandom));
    end
    wait_idle();
    chk(exp_q.size() == 0, "R6", "all written chars sent in order", exp_q.size(), 0);
  endtask

  task automatic width_of_start(input logic s, input logic [1:0] q, input int want);
    int w = 0, guard = 0;
    sync = s; sel = q; len = 2'b11; md = 1'b0;
    put(8'hFF, 1'b0);
    while (txd !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
    while (txd === 1'b0 && w < 200) begin @(negedge clk); w++; end
    chk(w == want, "R4", "start bit width", w, want);
    wait_idle();
  endtask

  initial begin
    int lows;
    void'($urandom(32'd715));
    repeat (4) @(negedge clk);
    chk(txd === 1'b1 && rts === 1'b0, "R1", "line idle in reset", int'({txd, rts}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1 && rts === 1'b0, "R1", "line after reset", int'({txd, rts}), 2);
    chk(empty === 1'b1 && full === 1'b0 && level === 3'd0, "R1", "fifo after reset",
        int'(level), 0);
    chk(ovf === 1'b0, "R1", "overflow after reset", int'(ovf), 0);

    // R4 bit periods
    width_of_start(1'b1, 2'b00, 1);
    width_of_start(1'b0, 2'b00, 8);
    width_of_start(1'b0, 2'b01, 16);
    width_of_start(1'b0, 2'b11, 32);

    // R2/R3 random frames across lengths and modes
    run_cfg(1'b1, 2'b00, 2'b00, 1'b0, 12);
    run_cfg(1'b1, 2'b00, 2'b01, 1'b1, 12);
    run_cfg(1'b1, 2'b00, 2'b10, 1'b0, 12);
    run_cfg(1'b1, 2'b00, 2'b11, 1'b1, 12);
    run_cfg(1'b0, 2'b00, 2'b11, 1'b1, 6);
    run_cfg(1'b0, 2'b01, 2'b00, 1'b1, 4);
    run_cfg(1'b0, 2'b10, 2'b10, 1'b0, 3);

    // R5: no bit enable, start bit holds
    mon_en = 1'b0; bit_en = 1'b0; sync = 1'b1; len = 2'b11; md = 1'b0;
    put(8'hFF, 1'b0);
    repeat (3) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      if (txd === 1'b0 && rts === 1'b1) lows++;
      @(negedge clk);
    end
    chk(lows == 10, "R5", "line frozen without bit enable", lows, 10);
    bit_en = 1'b1;
    wait_idle();
    exp_q.delete();
    mon_en = 1'b1;

    // R6/R7: fill under freeze, overflow
    sync = 1'b1; len = 2'b11; md = 1'b1;
    freeze = 1'b1;
    repeat (2) @(negedge clk);
    put(8'h11, 1'b1); put(8'h22, 1'b0); put(8'h33, 1'b0);
    chk(level === 3'd3 && !full && !empty, "R6", "level after 3 writes", int'(level), 3);
    put(8'h44, 1'b1);
    chk(full === 1'b1 && level === 3'd4, "R6", "full after 4 writes", int'(level), 4);
    put(8'h55, 1'b1);
    chk(ovf === 1'b1, "R7", "overflow pulse", int'(ovf), 1);
    @(negedge clk);
    chk(ovf === 1'b0, "R7", "overflow one cycle", int'(ovf), 0);
    chk(level === 3'd4 && exp_q.size() == 4, "R7", "dropped write not queued",
        int'(level), 4);
    chk(txd === 1'b1 && rts === 1'b0, "R8", "frozen empty snapshot stays idle",
        int'({txd, rts}), 2);
    freeze = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R9", "held chars sent after release", exp_q.size(), 0);

    // R8/R9: freeze with loaded FIFO
    put(8'hA1, 1'b0); put(8'hB2, 1'b1); put(8'hC3, 1'b0);
    freeze = 1'b1;
    @(negedge clk);
    put(8'hD4, 1'b1); put(8'hE5, 1'b0);
    repeat (80) @(negedge clk);
    chk(exp_q.size() == 2, "R8", "only pre-freeze chars sent", exp_q.size(), 2);
    chk(level === 3'd2, "R8", "later writes held", int'(level), 2);
    lows = 0;
    for (int i = 0; i < 30; i++) begin
      if (txd !== 1'b1 || rts !== 1'b0) lows++;
      @(negedge clk);
    end
    chk(lows == 0, "R8", "line idle while frozen", lows, 0);
    freeze = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R9", "resume sends remaining", exp_q.size(), 0);

    // R8: freeze mid-character with empty FIFO
    sync = 1'b0; sel = 2'b00; len = 2'b01; md = 1'b0;
    put(8'h2A, 1'b0);
    while (rts !== 1'b1) @(negedge clk);
    repeat (20) @(negedge clk);
    freeze = 1'b1;
    @(negedge clk);
    put(8'h15, 1'b0);
    repeat (200) @(negedge clk);
    chk(exp_q.size() == 1 && rts === 1'b0, "R8", "current frame completes, next held",
        exp_q.size(), 1);
    freeze = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R9", "resume after mid-frame freeze", exp_q.size(), 0);

    // random freeze toggling
    sync = 1'b1; len = 2'b10; md = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (($urandom % 5) == 0) freeze = ~freeze;
      if (!full && ($urandom % 2)) put(8'($urandom), 1'($urandom));
      else @(negedge clk);
    end
    freeze = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R9", "no loss under random freeze", exp_q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule